// File: doc/BRIEF.md
# Reloadable Down-Counter Bank

This block holds four independent 16-bit down-counters behind an 8-bit register bus with a 7-bit address. Every channel keeps three registers: a reload value that software fills one byte at a time, a running count, and a snapshot latch that software reads back one byte at a time. A shared tick input acts as the count enable. While the tick is high, each channel that is counting decrements once per clock. When a decrement lands on zero, the channel reloads its count from the reload value and raises a one-cycle event pulse on its own output bit.

Two write-triggered commands move data between the registers. A start command copies the reload value into the running count. A capture command copies the running count into the snapshot latch. A read therefore returns the value captured by the last capture command, not the live count.

Each channel is in one of two states, computed every cycle from its registers. In CH_IDLE the count and the reload value are both zero. In CH_RUN at least one of them is non-zero. A channel moves from CH_IDLE to CH_RUN on a reload byte write with non-zero data. It moves from CH_RUN to CH_IDLE when the count reaches zero through a decrement or a start command while the reload value is zero, or when both registers are zero at once.

Top module: `dcb_bank`

## Requirements
- R1: After reset, every reload value, count and snapshot latch is zero. Every read returns 0x00 and event_o is 0.
- R2: A write to channel offset 0x0 replaces bits 7:0 of that channel's reload value. Bits 15:8 keep their value.
- R3: A write to channel offset 0x4 replaces bits 15:8 of that channel's reload value. Bits 7:0 keep their value.
- R4: A write to channel offset 0x8 copies the reload value into the running count on that clock edge. The data byte is ignored.
- R5: A write to channel offset 0xC copies the running count into the snapshot latch. The data byte is ignored. A read of offset 0x0 returns latch bits 7:0 and a read of offset 0x4 returns latch bits 15:8, combinationally. The latch does not follow later counting.
- R6: In CH_RUN, each clock edge with tick_i high decrements the count by one. With tick_i low, the count holds.
- R7: When a ticked decrement brings the count from 1 to 0, the count takes the reload value instead. That channel's bit of event_o is high for exactly the one cycle after that edge.
- R8: A channel whose count and reload value are both zero (CH_IDLE) ignores ticks and never raises an event.
- R9: When a start command and a tick arrive in the same cycle, the start command wins. The count becomes the reload value with no decrement.
- R10: Channel n (0..3) decodes at address 0x40 + 0x10*n. Commands act only on the addressed channel. The tick acts on all channels independently.
- R11: A ticked decrement of a count of zero with a non-zero reload value wraps the count to 0xFFFF and raises no event.
- R12: Writes to addresses outside the channel windows, or to other offsets, change no state. Reads of any address other than offsets 0x0 and 0x4 in a channel window return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, shared by all channels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| event_o | output | 4 | Per-channel wrap pulse |

## Verification
A corrupted count or reload register stays hidden until software captures the count, or until the count reaches zero and event_o pulses at the wrong tick. The bench therefore captures and reads back after every stimulus pattern, so an error in state shows within a few cycles. Wrong priority between a start command and a tick shows as a captured value one lower than the reload value. A decode slip shows as a value in a channel that was never addressed, or as a non-zero read of a hole in the address map.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RLD_LO,
        CMD_RLD_HI,
        CMD_GO,
        CMD_CAPTURE
    } cmd_e;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;
endpackage

// File: rtl/dcb_decode.sv
module dcb_decode
    import dcb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = ADDR_W
) (
    input  logic              wr_en_i,
    input  logic [AW-1:0]     addr_i,
    output cmd_e              cmd_o [NUM_CH],
    output logic [NUM_CH-1:0] rd_sel_o,
    output logic              rd_hi_o
);
    localparam int IDX_W = AW - 5;

    logic [IDX_W-1:0] idx;
    logic [3:0]       off;
    logic             win;
    cmd_e             op;

    always_comb begin
        idx = addr_i[AW-2:4];
        off = addr_i[3:0];
        win = addr_i[AW-1] && (int'(idx) < NUM_CH);
        unique case (off)
            4'h0:    op = CMD_RLD_LO;
            4'h4:    op = CMD_RLD_HI;
            4'h8:    op = CMD_GO;
            4'hC:    op = CMD_CAPTURE;
            default: op = CMD_NONE;
        endcase
        rd_hi_o = (off == 4'h4);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            cmd_o[g]    = (wr_en_i && win && idx == IDX_W'(g)) ? op : CMD_NONE;
            rd_sel_o[g] = win && idx == IDX_W'(g) && (off == 4'h0 || off == 4'h4);
        end
    end
endmodule

// File: rtl/dcb_channel.sv
module dcb_channel
    import dcb_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  cmd_e          cmd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [CW-1:0] snap_o,
    output logic          event_o
);
    logic [CW-1:0] rld_q, rld_d, cnt_q, cnt_d, snap_q, snap_d;
    logic          evt_q, evt_d;
    ch_state_e     state;

    always_comb begin
        state = (cnt_q == '0 && rld_q == '0) ? CH_IDLE : CH_RUN;
    end

    always_comb begin
        rld_d  = rld_q;
        cnt_d  = cnt_q;
        snap_d = snap_q;
        evt_d  = 1'b0;
        case (cmd_i)
            CMD_RLD_LO:  rld_d[DW-1:0]  = wdata_i;
            CMD_RLD_HI:  rld_d[CW-1:DW] = wdata_i;
            CMD_GO:      cnt_d = rld_q;
            CMD_CAPTURE: snap_d = cnt_q;
            default:     ;
        endcase
        if (tick_i && cmd_i != CMD_GO) begin
            unique case (state)
                CH_RUN: begin
                    if (cnt_q == CW'(1)) begin
                        cnt_d = rld_q;
                        evt_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                CH_IDLE: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rld_q  <= '0;
            cnt_q  <= '0;
            snap_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            rld_q  <= rld_d;
            cnt_q  <= cnt_d;
            snap_q <= snap_d;
            evt_q  <= evt_d;
        end
    end

    assign snap_o  = snap_q;
    assign event_o = evt_q;

    assert_go_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == CMD_GO |=> cnt_q == $past(rld_q));
    assert_go_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_GO && tick_i) |=> !evt_q);
    assert_capture_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == CMD_CAPTURE |=> snap_q == $past(cnt_q));
    assert_step_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cmd_i != CMD_GO && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));
    assert_hold_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && cmd_i != CMD_GO) |=> $stable(cnt_q));
    assert_event_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_q |-> ($past(tick_i) && $past(cnt_q) == CW'(1) && cnt_q == $past(rld_q)));
    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '0 && rld_q == '0) |=> (cnt_q == '0 && !evt_q));
endmodule

// File: rtl/dcb_rdmux.sv
module dcb_rdmux
    import dcb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = CNT_W,
    parameter int DW     = DATA_W
) (
    input  logic [NUM_CH-1:0][CW-1:0] snap_i,
    input  logic [NUM_CH-1:0]         rd_sel_i,
    input  logic                      rd_hi_i,
    output logic [DW-1:0]             rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_sel_i[c]) begin
                rdata_o = rdata_o | (rd_hi_i ? snap_i[c][CW-1:DW] : snap_i[c][DW-1:0]);
            end
        end
    end
endmodule

// File: rtl/dcb_bank.sv
module dcb_bank
    import dcb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CH-1:0] event_o
);
    cmd_e                        cmd [NUM_CH];
    logic [NUM_CH-1:0]           rd_sel;
    logic                        rd_hi;
    logic [NUM_CH-1:0][CNT_W-1:0] snap;
    logic [NUM_CH-1:0]           cmd_act;

    dcb_decode #(.NUM_CH(NUM_CH), .AW(ADDR_W)) u_decode (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .cmd_o   (cmd),
        .rd_sel_o(rd_sel),
        .rd_hi_o (rd_hi)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign cmd_act[g] = (cmd[g] != CMD_NONE);
        dcb_channel #(.CW(CNT_W), .DW(DATA_W)) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tick_i (tick_i),
            .cmd_i  (cmd[g]),
            .wdata_i(wdata_i),
            .snap_o (snap[g]),
            .event_o(event_o[g])
        );
    end

    dcb_rdmux #(.NUM_CH(NUM_CH), .CW(CNT_W), .DW(DATA_W)) u_rdmux (
        .snap_i  (snap),
        .rd_sel_i(rd_sel),
        .rd_hi_i (rd_hi),
        .rdata_o (rdata_o)
    );

    assert_one_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cmd_act));
    assert_no_cmd_idle_bus_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |-> cmd_act == '0);
endmodule

// File: tb/dcb_bank_tb_top.sv
`timescale 1ns/1ps
module dcb_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    wire  [7:0] rdata;
    wire  [3:0] evt;

    always #10 clk = ~clk;

    dcb_bank dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_i (tick),
        .wr_en_i(wr_en),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .event_o(evt)
    );

    typedef struct {
        logic [15:0] val;
        string       req;
    } item_t;

    item_t       exp_q[$];
    logic [15:0] act;
    event        got_ev;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    initial begin : monitor
        item_t it;
        forever begin
            @(got_ev);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: result %h with no expected item", act);
            end else begin
                it = exp_q.pop_front();
                if (act !== it.val) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.val);
                end
            end
        end
    end

    task automatic push_exp(input logic [15:0] v, input string r);
        item_t it;
        it.val = v;
        it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [7:0] e, input string r);
        push_exp({8'h00, e}, r);
        @(negedge clk);
        addr = a;
        #1 act = {8'h00, rdata};
        -> got_ev;
        #1;
    endtask

    task automatic evt_chk(input logic [3:0] e, input string r);
        push_exp({12'h000, e}, r);
        #1 act = {12'h000, evt};
        -> got_ev;
        #1;
    endtask

    task automatic cap_rd(input int ch, input logic [15:0] e, input string r);
        wr(7'(8'h4C + 8'(16 * ch)), 8'h5A);
        rd_chk(7'(8'h40 + 8'(16 * ch)), e[7:0], r);
        rd_chk(7'(8'h44 + 8'(16 * ch)), e[15:8], r);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(7'h40, 8'h00, "R1");
        rd_chk(7'h74, 8'h00, "R1");
        evt_chk(4'h0, "R1");
        // R3 / R2: byte-wise reload writes
        wr(7'h40, 8'h34);
        wr(7'h44, 8'h12);
        wr(7'h48, 8'hFF);
        cap_rd(0, 16'h1234, "R3");
        wr(7'h40, 8'hAB);
        wr(7'h48, 8'h00);
        cap_rd(0, 16'h12AB, "R2");
        // R4 / R6 / R5: counting and stale snapshot
        ticks(5);
        rd_chk(7'h40, 8'hAB, "R5");
        cap_rd(0, 16'h12A6, "R6");
        repeat (5) @(negedge clk);
        cap_rd(0, 16'h12A6, "R6");
        // R7 / R10: wrap and event on channel 1
        wr(7'h50, 8'h03);
        wr(7'h58, 8'h00);
        cap_rd(1, 16'h0003, "R4");
        rd_chk(7'h44, 8'h12, "R10");
        ticks(2);
        evt_chk(4'h0, "R7");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        evt_chk(4'b0010, "R7");
        @(negedge clk);
        evt_chk(4'h0, "R7");
        cap_rd(1, 16'h0003, "R7");
        rd_chk(7'h40, 8'hA6, "R10");
        // R9: start command and tick together
        wr(7'h50, 8'h10);
        @(negedge clk);
        wr_en = 1'b1; addr = 7'h58; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; tick = 1'b0;
        cap_rd(1, 16'h0010, "R9");
        // R12: stray writes and holes in the map
        wr(7'h30, 8'hFF);
        wr(7'h08, 8'hFF);
        wr(7'h4D, 8'h77);
        rd_chk(7'h30, 8'h00, "R12");
        rd_chk(7'h48, 8'h00, "R12");
        rd_chk(7'h4C, 8'h00, "R12");
        wr(7'h48, 8'h00);
        cap_rd(0, 16'h12AB, "R12");
        // R11: zero count with non-zero reload wraps silently
        wr(7'h60, 8'h05);
        ticks(1);
        evt_chk(4'h0, "R11");
        cap_rd(2, 16'hFFFF, "R11");
        // R8: channel 3 never loaded stays idle
        cap_rd(3, 16'h0000, "R8");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule